// File: doc/BRIEF.md
# Direct-Mapped Branch Target Predictor

This block sits beside the fetch stage and guesses, in the same cycle that a program counter is presented, where fetch should go next. It keeps a small table of recently resolved branches. Each slot is picked by the low bits of the fetch address. Each slot holds a valid flag, the high address bits as a tag, the branch's destination and a single direction bit. A lookup that finds a valid slot with a matching tag marks the fetched word as a branch. It also reports the stored direction and the stored destination, and it forms the next fetch address from them.

When a branch resolves later in the pipeline, its address, its real destination and whether it was taken come back on a write port. The slot that the address maps to is claimed or overwritten with the new tag, destination and direction. The write lands on the clock edge, so a lookup in the same cycle still sees the previous slot contents. The lookup path is purely combinational. The block has no state machine. Its only sequential elements are the slot arrays, written on the rising clock edge and with the valid flags cleared by an active-low asynchronous reset. The next-address selection is a three-way choice: miss, hit predicting not taken, and hit predicting taken.

Top module: `btc_predictor`

## Requirements
- R1: After reset every slot is invalid, so no fetch address produces a hit until a write has been made.
- R2: The slot is chosen by fetch address bits [3:0], and the lookup hits only when that slot is valid and its stored tag equals address bits [8:4].
- R3: On a hit, the predicted destination output equals the destination last written to that slot. On a miss it is zero.
- R4: The predicted-taken output equals the slot's direction bit on a hit (1 = taken, 0 = not taken) and is 0 on a miss.
- R5: The next fetch address is the predicted destination when the lookup hits and predicts taken. Otherwise it is the fetch address plus one, wrapping from 511 to 0.
- R6: A write with the write strobe high stores the tag, destination and resolved direction of its branch address into the slot that address maps to. A different address that maps to the same slot then misses.
- R7: When a write and a lookup touch the same slot in one cycle, the lookup returns the slot's old contents, and the written values are returned from the next cycle onward.
- R8: Write inputs presented while the write strobe is low change no slot.
- R9: All lookup outputs follow the fetch address within the same cycle, without a clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; slot writes occur on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears all valid flags |
| lk_pc | input | 9 | Fetch address being looked up |
| lk_hit | output | 1 | Valid slot with matching tag; the fetched word is a known branch |
| lk_taken | output | 1 | Prediction that the branch is taken |
| lk_target | output | 9 | Stored destination on a hit, zero otherwise |
| lk_next_pc | output | 9 | Address fetch should use in the next cycle |
| wr_en | input | 1 | Write strobe for a resolved branch |
| wr_pc | input | 9 | Address of the resolved branch |
| wr_target | input | 9 | Real destination of the resolved branch |
| wr_taken | input | 1 | Resolved direction, 1 when taken |

## Verification
The bench builds the block with its default 9-bit address and 4 index bits, so the 16 slots and 32 tags are small enough to reach in a few thousand cycles. Random addresses are drawn from a narrowed pool of four tags across all sixteen slots. This produces many hits, many evictions by aliasing addresses, and frequent same-slot write-and-read collisions. Directed cases cover the full address sweep after reset, a lookup at the wrap from 511 to 0, aliasing eviction, a collision in a single cycle, and writes with the strobe low.

// File: rtl/btc_pkg.sv
package btc_pkg;

    // Outcome of one lookup, used to steer the next fetch address
    typedef enum logic [1:0] {
        LK_MISS   = 2'd0,
        LK_HIT_NT = 2'd1,
        LK_HIT_T  = 2'd2
    } lk_kind_e;

endpackage

// File: rtl/btc_store.sv
module btc_store #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 5,
    parameter int PC_W  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PC_W-1:0]  wr_tgt,
    input  logic             wr_dir,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [PC_W-1:0]  rd_tgt,
    output logic             rd_dir
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [PC_W-1:0]  tgt_q [DEPTH];
    logic [DEPTH-1:0] dir_q;

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(e));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q[e] <= 1'b0;
            end else if (sel) begin
                valid_q[e] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                tag_q[e] <= wr_tag;
                tgt_q[e] <= wr_tgt;
                dir_q[e] <= wr_dir;
            end
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_tgt   = tgt_q[rd_idx];
    assign rd_dir   = dir_q[rd_idx];

    // R6: a strobed write leaves its slot valid
    a_r6_write_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(wr_idx)]);

    // R8: without a strobe the valid flags stay as they were
    a_r8_idle_keeps_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(valid_q));

endmodule

// File: rtl/btc_match.sv
module btc_match #(
    parameter int TAG_W = 5
) (
    input  logic             slot_valid,
    input  logic [TAG_W-1:0] slot_tag,
    input  logic             slot_dir,
    input  logic [TAG_W-1:0] pc_tag,
    output logic             hit,
    output logic             taken
);
    always_comb begin
        hit   = slot_valid && (slot_tag == pc_tag);
        taken = hit && slot_dir;
    end
endmodule

// File: rtl/btc_predictor.sv
module btc_predictor #(
    parameter int PC_W  = 9,
    parameter int IDX_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic            lk_taken,
    output logic [PC_W-1:0] lk_target,
    output logic [PC_W-1:0] lk_next_pc,
    input  logic            wr_en,
    input  logic [PC_W-1:0] wr_pc,
    input  logic [PC_W-1:0] wr_target,
    input  logic            wr_taken
);
    import btc_pkg::*;

    localparam int TAG_W = PC_W - IDX_W;

    logic             s_valid;
    logic [TAG_W-1:0] s_tag;
    logic [PC_W-1:0]  s_tgt;
    logic             s_dir;
    logic             m_hit;
    logic             m_taken;
    lk_kind_e         kind;

    btc_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_pc[IDX_W-1:0]),
        .wr_tag   (wr_pc[PC_W-1:IDX_W]),
        .wr_tgt   (wr_target),
        .wr_dir   (wr_taken),
        .rd_idx   (lk_pc[IDX_W-1:0]),
        .rd_valid (s_valid),
        .rd_tag   (s_tag),
        .rd_tgt   (s_tgt),
        .rd_dir   (s_dir)
    );

    btc_match #(.TAG_W(TAG_W)) u_match (
        .slot_valid (s_valid),
        .slot_tag   (s_tag),
        .slot_dir   (s_dir),
        .pc_tag     (lk_pc[PC_W-1:IDX_W]),
        .hit        (m_hit),
        .taken      (m_taken)
    );

    always_comb begin
        if (!m_hit)      kind = LK_MISS;
        else if (m_taken) kind = LK_HIT_T;
        else             kind = LK_HIT_NT;
    end

    always_comb begin
        lk_hit     = 1'b0;
        lk_taken   = 1'b0;
        lk_target  = '0;
        lk_next_pc = lk_pc + PC_W'(1);
        unique case (kind)
            LK_MISS: ;
            LK_HIT_NT: begin
                lk_hit    = 1'b1;
                lk_target = s_tgt;
            end
            LK_HIT_T: begin
                lk_hit     = 1'b1;
                lk_taken   = 1'b1;
                lk_target  = s_tgt;
                lk_next_pc = s_tgt;
            end
            default: ;
        endcase
    end

    // R7: a write becomes visible to a lookup of the same address one cycle later
    a_r7_write_visible_next: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((lk_pc != $past(wr_pc)) ||
                   (lk_hit && (lk_target == $past(wr_target)) && (lk_taken == $past(wr_taken)))));

    // R4: a taken prediction only comes with a hit
    a_r4_taken_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        lk_taken |-> lk_hit);

    // R5: a hit predicting taken redirects fetch to the predicted destination
    a_r5_redirect_to_target: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_taken) |-> (lk_next_pc == lk_target));

    // R5: otherwise fetch falls through to the next sequential address
    a_r5_fall_through: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_taken |-> (lk_next_pc == PC_W'(lk_pc + PC_W'(1))));

endmodule

// File: tb/btc_predictor_bench.sv
module btc_predictor_bench;
    localparam int PC_W  = 9;
    localparam int IDX_W = 4;
    localparam int DEPTH = 1 << IDX_W;
    localparam int TAG_W = PC_W - IDX_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic            lk_hit, lk_taken;
    logic [PC_W-1:0] lk_target, lk_next_pc;
    logic            wr_en = 1'b0;
    logic [PC_W-1:0] wr_pc = '0;
    logic [PC_W-1:0] wr_target = '0;
    logic            wr_taken = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    logic             m_valid [DEPTH];
    logic [TAG_W-1:0] m_tag   [DEPTH];
    logic [PC_W-1:0]  m_tgt   [DEPTH];
    logic             m_dir   [DEPTH];

    always #5 clk = ~clk;

    btc_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) u_btc_predictor (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit),
        .lk_taken(lk_taken), .lk_target(lk_target), .lk_next_pc(lk_next_pc),
        .wr_en(wr_en), .wr_pc(wr_pc), .wr_target(wr_target), .wr_taken(wr_taken)
    );

    function automatic logic exp_hit(input logic [PC_W-1:0] pc);
        int i = int'(pc[IDX_W-1:0]);
        return m_valid[i] && (m_tag[i] == pc[PC_W-1:IDX_W]);
    endfunction

    function automatic logic [PC_W-1:0] exp_target(input logic [PC_W-1:0] pc);
        return exp_hit(pc) ? m_tgt[int'(pc[IDX_W-1:0])] : '0;
    endfunction

    function automatic logic exp_taken(input logic [PC_W-1:0] pc);
        return exp_hit(pc) && m_dir[int'(pc[IDX_W-1:0])];
    endfunction

    function automatic logic [PC_W-1:0] exp_next(input logic [PC_W-1:0] pc);
        return exp_taken(pc) ? exp_target(pc) : PC_W'(pc + 1);
    endfunction

    task automatic check(input string req, input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s pc=%0d actual=%0d expected=%0d", req, lk_pc, act, exp);
        end
    endtask

    task automatic check_all(input string ctx);
        check({ctx, "/R2 hit"},    PC_W'(lk_hit),   PC_W'(exp_hit(lk_pc)));
        check({ctx, "/R4 taken"},  PC_W'(lk_taken), PC_W'(exp_taken(lk_pc)));
        check({ctx, "/R3 target"}, lk_target,       exp_target(lk_pc));
        check({ctx, "/R5 next"},   lk_next_pc,      exp_next(lk_pc));
    endtask

    // One cycle: drive after the falling edge, check before the rising edge, then model the write
    task automatic step(input logic [PC_W-1:0] pc, input logic we, input logic [PC_W-1:0] wpc,
                        input logic [PC_W-1:0] wtgt, input logic wtk, input string ctx);
        @(negedge clk);
        lk_pc = pc; wr_en = we; wr_pc = wpc; wr_target = wtgt; wr_taken = wtk;
        #1;
        check_all(ctx);
        @(posedge clk);
        if (we) begin
            m_valid[int'(wpc[IDX_W-1:0])] = 1'b1;
            m_tag[int'(wpc[IDX_W-1:0])]   = wpc[PC_W-1:IDX_W];
            m_tgt[int'(wpc[IDX_W-1:0])]   = wtgt;
            m_dir[int'(wpc[IDX_W-1:0])]   = wtk;
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_valid[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; m_dir[i] = 1'b0;
        end
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: every address misses after reset, outputs follow the address at once (R9)
        @(negedge clk);
        for (int p = 0; p < (1 << PC_W); p++) begin
            lk_pc = PC_W'(p);
            #0.01;
            check("R1 hit after reset", PC_W'(lk_hit), '0);
        end

        // R5: wrap of the sequential address from 511 to 0
        step(9'd511, 1'b0, 9'd0, 9'd0, 1'b0, "R5 wrap");
        check("R5 wrap value", lk_next_pc, 9'd0);

        // R6: write taken branch, then read back
        step(9'd0,   1'b1, 9'h013, 9'h0A5, 1'b1, "R6 write");
        step(9'h013, 1'b0, 9'd0,   9'd0,   1'b0, "R6 readback");
        check("R6 target value", lk_target, 9'h0A5);

        // R6: aliasing address at same slot evicts the older branch
        step(9'h013, 1'b1, 9'h023, 9'h111, 1'b0, "R6 evict");
        step(9'h013, 1'b0, 9'd0,   9'd0,   1'b0, "R6 old misses");
        check("R6 alias miss", PC_W'(lk_hit), '0);
        step(9'h023, 1'b0, 9'd0,   9'd0,   1'b0, "R6 new hits nt");

        // R7: collision in one cycle returns old contents, new contents next cycle
        step(9'h023, 1'b1, 9'h023, 9'h1F0, 1'b1, "R7 same cycle");
        check("R7 old target", lk_target, 9'h111);
        step(9'h023, 1'b0, 9'd0,   9'd0,   1'b0, "R7 next cycle");
        check("R7 new next", lk_next_pc, 9'h1F0);

        // R8: write data without strobe leaves the slot untouched
        step(9'h023, 1'b0, 9'h023, 9'h055, 1'b0, "R8 no strobe");
        step(9'h023, 1'b0, 9'h0C4, 9'h077, 1'b1, "R8 after");
        check("R8 target kept", lk_target, 9'h1F0);

        // Random mix across all slots with four tags to force hits, evictions and collisions
        for (int n = 0; n < 3000; n++) begin
            logic [PC_W-1:0] pc, wpc, wtgt;
            logic we, wtk;
            pc   = {TAG_W'($urandom_range(0, 3)), IDX_W'($urandom_range(0, DEPTH - 1))};
            wpc  = ($urandom_range(0, 3) == 0) ? pc :
                   {TAG_W'($urandom_range(0, 3)), IDX_W'($urandom_range(0, DEPTH - 1))};
            wtgt = PC_W'($urandom);
            we   = ($urandom_range(0, 2) == 0);
            wtk  = $urandom_range(0, 1) == 1;
            step(pc, we, wpc, wtgt, wtk, "R9 random");
        end

        wr_en = 1'b0;
        finish_run();
    end
endmodule